// File: doc/BRIEF.md
# Edge-Latched Synchronous Bit-Wide RAM

A 4096-word by 1-bit static memory whose cycles are framed by an active-low chip enable and an active-low write enable. A fast sampling clock watches both strobes. Each strobe passes through a short synchronizer and is compared with its value one clock earlier to find its edges. The address and data-in inputs go through a pipeline of the same depth, so they stay aligned with the strobes.

When chip enable falls, the block captures the address. The write-enable level at that moment sets the kind of cycle. If write enable is low, the cycle is an early write: the data bit is stored at once and the output enable never turns on. If write enable is high, the cycle is a read: the output enable turns on after a set delay and the read data becomes valid after a second delay. A first falling edge of write enable inside a read cycle writes the data-in bit present at that edge. This covers both late write and read-modify-write. When chip enable returns high, the output turns off and the block waits for the next cycle. The output-enable flag stands in for a three-state pin.

Top module: `edge_ram`

## Requirements
- R1: Storage holds 4096 independent bits in a 64 x 64 array. Address bits [11:6] select the row and bits [5:0] select the column. A bit written at any address reads back unchanged after writes to all other addresses.
- R2: The address is captured on the falling edge of chip enable. Later changes on addr_i within the same cycle do not change which bit is read.
- R3: If we_ni is low when chip enable falls, d_i is captured and written, and oe_o stays 0 for the whole cycle.
- R4: If we_ni is high when chip enable falls, the cycle is a read. Let the fall be driven between two clock edges. oe_o rises after edge SYNC_STAGES+OE_DELAY, which is edge 4 with the defaults. q_o is valid after edge SYNC_STAGES+OE_DELAY+DATA_DELAY, which is edge 6 with the defaults.
- R5: In a read cycle, the first falling edge of we_ni writes the d_i value present at that edge (late write). Any further falling edges of we_ni in the same cycle write nothing.
- R6: In a read-modify-write, q_o first shows the old bit. After the write inside the same cycle, q_o shows the new bit.
- R7: Chip enable rising drives oe_o to 0 after edge SYNC_STAGES+1, which is edge 3 with the defaults. q_o is 0 whenever oe_o is 0.
- R8: A falling edge of we_ni while chip enable is high writes nothing, and the stored contents are kept.
- R9: While rst_ni is low and after its release, oe_o and q_o are 0. Reset does not clear the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Word address |
| d_i | input | 1 | Data-in bit |
| q_o | output | 1 | Read data, 0 when not valid |
| oe_o | output | 1 | Output drive enable (three-state stand-in) |

## Verification
Every strobe edge reaches the controller two clocks after it is driven and takes effect on the third. The bench drives inputs one time unit after a rising edge and samples at the same offset after later edges. It checks read timing at exact edge counts: oe_o is still low after edge 3 and high after edge 4, and q_o is wrong after edge 5 and correct after edge 6. It checks that oe_o is still high after the second edge following chip enable rising and low after the third. Write checks wait at least four edges before the strobe is released, so the write is certain to have landed. Read-back values come from a pattern function of the address.

// File: rtl/edge_ram_pkg.sv
package edge_ram_pkg;
  typedef enum logic [1:0] {CYC_IDLE, CYC_READ, CYC_EARLY} cyc_e;
endpackage

// File: rtl/edge_ram_sync.sv
module edge_ram_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[g] <= RST_VAL;
        else if (g == 0) pipe[g] <= d_i;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= RST_VAL;
    else prev_o <= pipe[STAGES-1];
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/edge_ram_array.sv
module edge_ram_array #(
  parameter int unsigned ROW_BITS = 6,
  parameter int unsigned COL_BITS = 6,
  localparam int unsigned AW = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS = 1 << ROW_BITS,
  localparam int unsigned COLS = 1 << COL_BITS
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wd_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rd_o
);
  logic [ROWS-1:0][COLS-1:0] cells;
  logic [ROW_BITS-1:0] wrow, rrow;
  logic [COL_BITS-1:0] wcol, rcol;

  assign wrow = waddr_i[AW-1:COL_BITS];
  assign wcol = waddr_i[COL_BITS-1:0];
  assign rrow = raddr_i[AW-1:COL_BITS];
  assign rcol = raddr_i[COL_BITS-1:0];

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk_i) begin
        if (we_i && wrow == ROW_BITS'(r)) cells[r][wcol] <= wd_i;
      end
    end
  endgenerate

  assign rd_o = cells[rrow][rcol];
endmodule

// File: rtl/edge_ram_ctrl.sv
module edge_ram_ctrl
  import edge_ram_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned OE_DELAY = 2,
  parameter int unsigned DATA_DELAY = 2,
  localparam int unsigned LIMIT = OE_DELAY + DATA_DELAY,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_s_i,
  input  logic          ce_p_i,
  input  logic          we_s_i,
  input  logic          we_p_i,
  input  logic [AW-1:0] addr_s_i,
  input  logic          d_s_i,
  input  logic          rd_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_d_o,
  output logic [AW-1:0] addr_q_o,
  output cyc_e          cyc_o,
  output logic          wr_done_o,
  output logic          oe_o,
  output logic          q_o
);
  cyc_e             cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    addr_q;
  logic             wr_done_q;
  logic             ce_fall, we_fall, valid;

  assign ce_fall = ce_p_i & ~ce_s_i;
  assign we_fall = we_p_i & ~we_s_i;

  always_comb begin
    mem_we_o   = 1'b0;
    mem_addr_o = addr_q;
    mem_d_o    = d_s_i;
    if (cyc_q == CYC_IDLE && ce_fall && !we_s_i) begin
      mem_we_o   = 1'b1;
      mem_addr_o = addr_s_i;
    end else if (cyc_q == CYC_READ && !ce_s_i && we_fall && !wr_done_q) begin
      mem_we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q     <= CYC_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      wr_done_q <= 1'b0;
    end else if (cyc_q == CYC_IDLE) begin
      if (ce_fall) begin
        addr_q    <= addr_s_i;
        cyc_q     <= we_s_i ? CYC_READ : CYC_EARLY;
        cnt_q     <= CNT_W'(1);
        wr_done_q <= !we_s_i;
      end
    end else if (ce_s_i) begin
      cyc_q     <= CYC_IDLE;
      cnt_q     <= '0;
      wr_done_q <= 1'b0;
    end else if (cyc_q == CYC_READ) begin
      if (cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + CNT_W'(1);
      if (mem_we_o) wr_done_q <= 1'b1;
    end
  end

  assign oe_o      = (cyc_q == CYC_READ) && (cnt_q >= CNT_W'(OE_DELAY));
  assign valid     = (cyc_q == CYC_READ) && (cnt_q >= CNT_W'(LIMIT));
  assign q_o       = valid & rd_i;
  assign addr_q_o  = addr_q;
  assign cyc_o     = cyc_q;
  assign wr_done_o = wr_done_q;
endmodule

// File: rtl/edge_ram.sv
module edge_ram
  import edge_ram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 6,
  parameter int unsigned COL_BITS = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OE_DELAY = 2,
  parameter int unsigned DATA_DELAY = 2,
  localparam int unsigned AW = ROW_BITS + COL_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          d_i,
  output logic          q_o,
  output logic          oe_o
);
  logic [1:0]    strb_s, strb_p;
  logic [AW:0]   dat_s, dat_p;
  logic          mem_we, mem_d, rd_bit, wr_done;
  logic [AW-1:0] mem_addr, addr_q;
  cyc_e          cyc;

  edge_ram_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb_sync (
    .clk_i, .rst_ni, .d_i({ce_ni, we_ni}), .q_o(strb_s), .prev_o(strb_p)
  );

  edge_ram_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk_i, .rst_ni, .d_i({addr_i, d_i}), .q_o(dat_s), .prev_o(dat_p)
  );

  edge_ram_ctrl #(.AW(AW), .OE_DELAY(OE_DELAY), .DATA_DELAY(DATA_DELAY)) u_ctrl (
    .clk_i, .rst_ni,
    .ce_s_i(strb_s[1]), .ce_p_i(strb_p[1]),
    .we_s_i(strb_s[0]), .we_p_i(strb_p[0]),
    .addr_s_i(dat_s[AW:1]), .d_s_i(dat_s[0]), .rd_i(rd_bit),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_d_o(mem_d),
    .addr_q_o(addr_q), .cyc_o(cyc), .wr_done_o(wr_done),
    .oe_o, .q_o
  );

  edge_ram_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk_i, .we_i(mem_we), .waddr_i(mem_addr), .wd_i(mem_d),
    .raddr_i(addr_q), .rd_o(rd_bit)
  );

  logic unused_p;
  assign unused_p = ^dat_p;
endmodule

// File: rtl/edge_ram_chk.sv
module edge_ram_chk
  import edge_ram_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          oe_o,
  input logic          q_o,
  input cyc_e          cyc,
  input logic [AW-1:0] addr_q,
  input logic          wr_done,
  input logic          mem_we
);
  AST_EARLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc == CYC_EARLY |-> !oe_o); // R3
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> cyc == CYC_READ); // R4
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != CYC_IDLE && $past(cyc) != CYC_IDLE) |-> $stable(addr_q)); // R2
  AST_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != CYC_IDLE && $past(cyc) != CYC_IDLE && $past(wr_done)) |-> !mem_we); // R5
  AST_Q_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !q_o); // R7
endmodule

bind edge_ram edge_ram_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .oe_o, .q_o, .cyc, .addr_q, .wr_done, .mem_we
);

// File: tb/edge_ram_tb.sv
`timescale 1ns/1ps
module edge_ram_tb;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, d = 0;
  logic [11:0] addr = '0;
  logic q, oe;
  int checks = 0, fails = 0, cyc = 0;
  logic oe_seen;

  always #2.5 clk = ~clk;

  edge_ram u_dut (.clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
                  .addr_i(addr), .d_i(d), .q_o(q), .oe_o(oe));

  function automatic logic pat(logic [11:0] a);
    return ^(a & 12'hA5C) ^ a[11] ^ a[0];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      oe_seen = oe_seen | oe;
    end
  endtask

  task automatic wr_early(logic [11:0] a, logic v);
    addr = a; d = v; we_n = 0; tick(1);
    oe_seen = 0; ce_n = 0; tick(4);
    ce_n = 1; we_n = 1; tick(4);
  endtask

  task automatic rd(logic [11:0] a, output logic v);
    addr = a; we_n = 1; tick(1);
    ce_n = 0; tick(6); v = q;
    ce_n = 1; tick(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic v;
    oe_seen = 0;
    tick(2);
    chk("R9 reset oe", oe, 0); chk("R9 reset q", q, 0);
    rst_n = 1; tick(3);
    chk("R9 after reset oe", oe, 0); chk("R9 after reset q", q, 0);

    // R1/R3: early write every address, output must stay off
    for (int a = 0; a < 4096; a++) begin
      wr_early(12'(a), pat(12'(a)));
      if (a % 512 == 0) chk("R3 early write oe quiet", oe_seen, 0);
    end
    // R1: read back all
    for (int a = 0; a < 4096; a++) begin
      rd(12'(a), v);
      chk($sformatf("R1 readback addr %0d", a), v, pat(12'(a)));
    end

    // R4: read timing
    addr = 12'h123; tick(1);
    ce_n = 0; tick(3); chk("R4 oe not yet after edge 3", oe, 0);
    tick(1); chk("R4 oe on after edge 4", oe, 1);
    tick(1); chk("R4 q not valid after edge 5", q, 0);
    tick(1); chk("R4 q valid after edge 6", q, pat(12'h123));
    // R2: address change after capture
    addr = 12'h124; tick(3);
    chk("R2 address held", q, pat(12'h123));
    // R7: disable timing
    ce_n = 1; tick(2); chk("R7 oe still on after edge 2", oe, 1);
    tick(1); chk("R7 oe off after edge 3", oe, 0);
    chk("R7 q zero when off", q, 0);
    tick(2);

    // R5: late write then ignored second write-enable edge
    addr = 12'h0F0; we_n = 1; tick(1);
    ce_n = 0; tick(3);
    d = ~pat(12'h0F0); we_n = 0; tick(4);
    we_n = 1; d = pat(12'h0F0); tick(3);
    we_n = 0; tick(4);
    ce_n = 1; we_n = 1; tick(4);
    rd(12'h0F0, v); chk("R5 late write first edge only", v, ~pat(12'h0F0));

    // R6: read-modify-write
    addr = 12'hA0A; we_n = 1; tick(1);
    ce_n = 0; tick(6); chk("R6 old value", q, pat(12'hA0A));
    d = ~pat(12'hA0A); we_n = 0; tick(4);
    chk("R6 new value same cycle", q, ~pat(12'hA0A));
    ce_n = 1; we_n = 1; tick(4);
    rd(12'hA0A, v); chk("R6 stored", v, ~pat(12'hA0A));

    // R8: write-enable edge while disabled
    addr = 12'h555; d = ~pat(12'h555); tick(1);
    we_n = 0; tick(5); chk("R8 oe off", oe, 0);
    we_n = 1; tick(3);
    rd(12'h555, v); chk("R8 ignored while disabled", v, pat(12'h555));
    rd(12'h556, v); chk("R8 neighbour kept", v, pat(12'h556));

    // R9: reset keeps contents
    rst_n = 0; tick(2); chk("R9 reset oe mid-run", oe, 0);
    rst_n = 1; tick(3);
    rd(12'h777, v); chk("R9 contents survive reset", v, pat(12'h777));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule